// File: doc/BRIEF.md
# Frame-Synchronous Byte Descrambler

This block removes a frame-synchronous scrambling pattern from a byte-wide data stream. The pattern comes from a 7-stage linear feedback generator with polynomial 1 + x^6 + x^7, so the bit sequence repeats every 127 bits. The block advances the generator eight bit steps in every accepted byte. The most significant data bit meets the first step. Each data bit is combined by XOR with the bit taken from the last (x^7) stage. Because XOR with the same sequence undoes itself, the same block also works as a scrambler.

An upstream frame counter provides two strobes. The seed strobe marks the byte that directly follows the final byte of the first overhead row. On that byte the generator restarts from all ones, and the byte's MSB takes the first bit of the fresh sequence. The skip strobe marks framing and identification bytes. These pass through unchanged and do not use up any of the sequence. Between seed strobes the sequence carries on without a break. While the enable input is low, data passes through unchanged, but the generator keeps stepping so that it stays aligned.

A two-state controller sets the behaviour. After reset it sits in `ST_IDLE`, where bytes pass through because no frame alignment is known yet. The transition `T_ARM` (a valid byte with the seed strobe) moves it to `ST_RUN`. It stays in `ST_RUN` (transition `T_HOLD`) until the next reset. The output is registered, so it appears one clock after the input.

Top module: `fsync_descrambler`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `out_data` is 8'h00.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and each result byte appears one clock after its input byte.
- R3: From reset until the first valid byte carrying `seed_strb`, every valid byte leaves the block unchanged.
- R4: A valid byte carrying `seed_strb` (with `enable` high) is XORed with the first keystream byte from the all-ones state, which is 8'hFE (bit 7 uses the first step). The following bytes are XORed with 8'h04 and then with the rest of the 1 + x^6 + x^7 sequence.
- R5: Clocks with `in_valid` low do not advance the sequence, so gaps leave the keystream continuous.
- R6: A valid byte with `skip_strb` high and `seed_strb` low leaves the block unchanged and does not advance the sequence. When the two strobes coincide, the seed strobe wins.
- R7: While `enable` is low, valid bytes leave the block unchanged but still advance the sequence. After `enable` returns high, the keystream continues as if it had been applied throughout.
- R8: A seed strobe in the middle of the stream restarts the sequence from all ones, so a zero byte produces 8'hFE.
- R9: The keystream repeats with a period of 127 bytes: the byte 127 positions after the seed byte is XORed with 8'hFE again.
- R10: While `in_valid` is low, `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 = apply the keystream, 0 = pass data through |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte, MSB first in time |
| seed_strb | input | 1 | Restart the generator from all ones on this byte |
| skip_strb | input | 1 | Overhead byte: pass through without advancing |
| out_valid | output | 1 | Result byte is present |
| out_data | output | 8 | Result byte |

## Verification
If the generator state is wrong, the next non-skipped byte in `ST_RUN` comes out with a wrong keystream pattern, one clock after that byte enters. The fault never goes away silently, since every later byte inherits it until the next seed strobe. A controller stuck in the wrong state shows on the first valid byte: a byte is scrambled before any seed, or a byte after the seed passes through unchanged. The bench therefore compares every output byte against an independent serial bit model. It also checks the fixed values 8'hFE and 8'h04 directly, so a wrong tap choice or a reversed bit order cannot go unnoticed.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    localparam int unsigned GEN_LEN = 7;
    localparam int unsigned TAP_HI  = GEN_LEN - 1;
    localparam int unsigned TAP_LO  = GEN_LEN - 2;

    typedef logic [GEN_LEN-1:0] gen_t;

    localparam gen_t GEN_SEED = '1;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } fsd_state_e;
endpackage

// File: rtl/fsd_keygen.sv
module fsd_keygen
    import fsd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  gen_t              st_i,
    output logic [BYTE_W-1:0] ks_o,
    output gen_t              st_o
);
    gen_t chain [0:BYTE_W];

    assign chain[0] = st_i;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_step
        assign ks_o[BYTE_W-1-i] = chain[i][TAP_HI];
        assign chain[i+1] = {chain[i][GEN_LEN-2:0], chain[i][TAP_HI] ^ chain[i][TAP_LO]};
    end

    assign st_o = chain[BYTE_W];
endmodule

// File: rtl/fsd_seqreg.sv
module fsd_seqreg
    import fsd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BYTE_W-1:0] ks_o
);
    gen_t cur_q;
    gen_t base;
    gen_t nxt;

    assign base = load_i ? GEN_SEED : cur_q;

    fsd_keygen #(.BYTE_W(BYTE_W)) u_kg (
        .st_i (base),
        .ks_o (ks_o),
        .st_o (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= GEN_SEED;
        end else if (adv_i) begin
            cur_q <= nxt;
        end
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) cur_q != '0); // R4
    AST_GEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !adv_i |=> $stable(cur_q)); // R5
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
    import fsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic seed_i,
    input  logic skip_i,
    input  logic enable_i,
    output logic load_o,
    output logic adv_o,
    output logic apply_o
);
    fsd_state_e state_q;
    fsd_state_e state_d;
    logic       arm;

    assign arm = valid_i && seed_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = 1'b0;
        adv_o   = 1'b0;
        apply_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o  = arm;
                adv_o   = arm;
                apply_o = arm && enable_i;
            end
            ST_RUN: begin
                load_o  = arm;
                adv_o   = arm || (valid_i && !skip_i);
                apply_o = (arm || (valid_i && !skip_i)) && enable_i;
            end
            default: begin
                load_o  = 1'b0;
                adv_o   = 1'b0;
                apply_o = 1'b0;
            end
        endcase
    end

    AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !arm) |=> state_q == ST_IDLE); // R3
    AST_STAY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> state_q == ST_RUN); // R8
    AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && skip_i && !seed_i) |-> !adv_o); // R6
endmodule

// File: rtl/fsync_descrambler.sv
module fsync_descrambler
    import fsd_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              seed_strb,
    input  logic              skip_strb,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);
    logic              load;
    logic              adv;
    logic              apply;
    logic [BYTE_W-1:0] ks;
    logic [BYTE_W-1:0] mask;

    fsd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .seed_i   (seed_strb),
        .skip_i   (skip_strb),
        .enable_i (enable),
        .load_o   (load),
        .adv_o    (adv),
        .apply_o  (apply)
    );

    fsd_seqreg #(.BYTE_W(BYTE_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (adv),
        .ks_o   (ks)
    );

    assign mask = apply ? ks : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data ^ mask;
            end
        end
    end

    AST_SEED_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seed_strb && enable) |=> out_data == ($past(in_data) ^ BYTE_W'(8'hFE))); // R4
    AST_SKIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skip_strb && !seed_strb) |=> out_data == $past(in_data)); // R6
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !enable) |=> out_data == $past(in_data)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R10
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_valid) |=> $rose(out_valid)); // R2
endmodule

// File: tb/sim_fsync_descrambler.sv
`timescale 1ns/1ps
module sim_fsync_descrambler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       seed_strb = 1'b0;
    logic       skip_strb = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [6:0] m_st = 7'h7F;
    bit         m_run = 0;

    always #4 clk = ~clk;

    fsync_descrambler u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
        .in_data(in_data), .seed_strb(seed_strb), .skip_strb(skip_strb),
        .out_valid(out_valid), .out_data(out_data)
    );

    // serial reference: one bit per step, output from stage 7
    function automatic logic [7:0] ref_ks(input logic [6:0] st);
        logic [6:0] s = st;
        logic [7:0] k = '0;
        for (int b = 7; b >= 0; b--) begin
            k[b] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] ref_next(input logic [6:0] st);
        logic [6:0] s = st;
        for (int b = 0; b < 8; b++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input string req, input logic [7:0] d, input bit sd,
                        input bit sk, input bit en, output logic [7:0] got);
        logic [7:0] exp;
        in_valid = 1'b1; in_data = d; seed_strb = sd; skip_strb = sk; enable = en;
        if (sd) begin
            exp = d ^ (en ? ref_ks(7'h7F) : 8'h00);
            m_st = ref_next(7'h7F);
            m_run = 1;
        end else if (!m_run || sk) begin
            exp = d;
        end else begin
            exp = d ^ (en ? ref_ks(m_st) : 8'h00);
            m_st = ref_next(m_st);
        end
        @(negedge clk);
        chk("R2", {7'd0, out_valid}, 8'h01);
        chk(req, out_data, exp);
        got = out_data;
    endtask

    task automatic gap(input int n);
        logic [7:0] held;
        in_valid = 1'b0; seed_strb = 1'b0; skip_strb = 1'b0; in_data = 8'hA5;
        held = out_data;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk("R2", {7'd0, out_valid}, 8'h00);
            chk("R10", out_data, held);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; seed_strb = 1'b0; skip_strb = 1'b0; enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", {7'd0, out_valid}, 8'h00);
        chk("R1", out_data, 8'h00);
        rst_n = 1'b1;
        m_st = 7'h7F; m_run = 0;
        @(negedge clk);
        chk("R1", {7'd0, out_valid}, 8'h00);
    endtask

    task automatic t_idle_pass;
        logic [7:0] g;
        push("R3", 8'h3C, 0, 0, 1, g);
        push("R3", 8'hFF, 0, 0, 1, g);
        push("R3", 8'h00, 0, 1, 1, g);
        gap(1);
    endtask

    task automatic t_seed_seq;
        logic [7:0] g;
        push("R4", 8'h00, 1, 0, 1, g);
        chk("R4", g, 8'hFE);
        push("R4", 8'h00, 0, 0, 1, g);
        chk("R4", g, 8'h04);
        for (int i = 0; i < 20; i++) push("R4", 8'(i * 37 + 5), 0, 0, 1, g);
    endtask

    task automatic t_gaps;
        logic [7:0] g;
        gap(3);
        for (int i = 0; i < 6; i++) push("R5", 8'(i * 11), 0, 0, 1, g);
        gap(2);
        push("R5", 8'h81, 0, 0, 1, g);
    endtask

    task automatic t_skip;
        logic [7:0] g;
        push("R6", 8'hF6, 0, 1, 1, g);
        push("R6", 8'h28, 0, 1, 1, g);
        for (int i = 0; i < 4; i++) push("R6", 8'(200 - i), 0, 0, 1, g);
        push("R6", 8'h00, 1, 1, 1, g);
        chk("R6", g, 8'hFE);
        push("R6", 8'h00, 0, 0, 1, g);
        chk("R6", g, 8'h04);
    endtask

    task automatic t_bypass;
        logic [7:0] g;
        for (int i = 0; i < 5; i++) push("R7", 8'(i + 90), 0, 0, 0, g);
        for (int i = 0; i < 5; i++) push("R7", 8'(i * 3), 0, 0, 1, g);
    endtask

    task automatic t_reseed;
        logic [7:0] g;
        push("R8", 8'h00, 1, 0, 1, g);
        chk("R8", g, 8'hFE);
        push("R8", 8'h55, 0, 0, 1, g);
        chk("R8", g, 8'h51);
    endtask

    task automatic t_period;
        logic [7:0] g;
        push("R9", 8'h00, 1, 0, 1, g);
        for (int i = 1; i < 127; i++) push("R9", 8'h00, 0, 0, 1, g);
        push("R9", 8'h00, 0, 0, 1, g);
        chk("R9", g, 8'hFE);
        push("R9", 8'h00, 0, 0, 1, g);
        chk("R9", g, 8'h04);
        gap(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_pass();
        t_seed_seq();
        t_gaps();
        t_skip();
        t_bypass();
        t_reseed();
        t_period();
        t_reset();
        t_idle_pass();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule